// File: doc/BRIEF.md
# Dual Wiper Register Bank

This block keeps the wiper state of two digitally controlled potentiometers. Each channel owns a volatile wiper register, whose 6-bit value is driven straight out as the channel's tap select (0 to 63), and four retained slots that hold saved positions. A serial front end, which is not part of this block, decodes host traffic into single-cycle commands. These commands read or write the wiper, read or write a slot, load a slot into the wiper, or save the wiper into a slot.

A sequencer with three states controls the block:

| State | Meaning | Transitions |
|---|---|---|
| ST_RECALL | Reset state, held for one cycle after reset is released. Each wiper is reloaded from its slot 0 and every command is refused. | Always moves to ST_IDLE. |
| ST_IDLE | Commands are accepted. | Moves to ST_STORE when a slot write or a save is accepted. |
| ST_STORE | A store is running for `STORE_CYCLES` cycles. Slot writes and saves are refused. Reads and wiper updates are still accepted. | Moves back to ST_IDLE when the countdown reaches its last cycle. |

The busy flag is high in every state except ST_IDLE. A lock input guards the retained slots only. Storage is modelled as flops. On reset, slot 0 of each channel takes its value from `INIT_TAPS` and the other slots clear to zero.

Top module: `dual_wiper_bank`

## Requirements
- R1: While reset is held, both tap selects read 0 and busy is 1. On the first clock edge after reset is released (ST_RECALL), each wiper loads its slot 0, so each tap select equals that channel's `INIT_TAPS` field. Channel p occupies bits p*6 and up.
- R2: A wiper write (`cmd_op`=1) sets the tap select of the channel named by `cmd_pot` to `cmd_wdata[5:0]` at the next edge. The other channel is left unchanged. This is accepted in ST_STORE and while `write_lock` is 1.
- R3: A wiper read (`cmd_op`=0) or a slot read (`cmd_op`=2, slot index `cmd_slot`) raises `rd_valid` for exactly one cycle after the command. In that cycle `rd_data` holds the value, with bits 7:6 equal to 0.
- R4: A slot write (`cmd_op`=3) stores only `cmd_wdata[5:0]`. A later read of that slot returns it with the upper bits 0.
- R5: A load (`cmd_op`=4) copies the named slot into the wiper, and the tap select shows the new value from the next edge on.
- R6: A save (`cmd_op`=5) copies the wiper into the named slot.
- R7: An accepted slot write or save holds busy high for exactly `STORE_CYCLES` cycles, starting at the next edge.
- R8: While busy is high, a slot write or save is refused. `cmd_refused` pulses on the next cycle and the slot keeps its value.
- R9: While `write_lock` is 1, a slot write or save is refused and the slot keeps its value. Wiper writes still take effect.
- R10: `cmd_op` values 6 and 7 are refused and change no state.
- R11: Any command given during ST_RECALL is refused and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Operation code (0 to 7) |
| cmd_pot | input | 1 | Channel select |
| cmd_slot | input | 2 | Retained slot index |
| cmd_wdata | input | 8 | Write data; only bits 5:0 are used |
| write_lock | input | 1 | Blocks slot writes and saves |
| tap_sel | output | 12 | Tap selects, 6 bits per channel |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read result, zero extended |
| busy | output | 1 | Sequencer is not idle |
| cmd_refused | output | 1 | Previous command was refused |

## Verification
The bench builds the block with `STORE_CYCLES`=5 and distinct reset values in slot 0 (42 for channel 0, 21 for channel 1). The short store window lets the bench watch the busy countdown end. It also lets commands land on the first and last cycles of that window. The two different reset values show that each channel recalls its own slot 0 rather than a shared constant. A behavioural model checks the outputs on every cycle, across directed cases and a long stretch of random commands with random lock settings.

// File: rtl/wbk_pkg.sv
package wbk_pkg;
    localparam logic [2:0] OP_RD_WIPER = 3'd0;
    localparam logic [2:0] OP_WR_WIPER = 3'd1;
    localparam logic [2:0] OP_RD_SLOT  = 3'd2;
    localparam logic [2:0] OP_WR_SLOT  = 3'd3;
    localparam logic [2:0] OP_LOAD     = 3'd4;
    localparam logic [2:0] OP_SAVE     = 3'd5;

    typedef enum logic [1:0] {
        ST_RECALL = 2'd0,
        ST_IDLE   = 2'd1,
        ST_STORE  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/wbk_seq.sv
module wbk_seq
    import wbk_pkg::*;
#(
    parameter int STORE_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic store_req,
    output logic in_recall,
    output logic in_store
);
    localparam int CW = $clog2(STORE_CYCLES + 1);

    seq_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RECALL: state_d = ST_IDLE;
            ST_IDLE:   if (store_req) state_d = ST_STORE;
            ST_STORE:  if (cnt_q == CW'(1)) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RECALL;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && store_req)
                cnt_q <= CW'(STORE_CYCLES);
            else if (state_q == ST_STORE)
                cnt_q <= cnt_q - CW'(1);
        end
    end

    always_comb begin
        in_recall = (state_q == ST_RECALL);
        in_store  = (state_q == ST_STORE);
    end
endmodule

// File: rtl/wbk_channel.sv
module wbk_channel #(
    parameter int TAPW  = 6,
    parameter int SLOTS = 4,
    parameter logic [TAPW-1:0] INIT = '0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     recall,
    input  logic                     wiper_we,
    input  logic [TAPW-1:0]          wiper_din,
    input  logic                     slot_we,
    input  logic [$clog2(SLOTS)-1:0] slot_idx,
    input  logic [TAPW-1:0]          slot_din,
    output logic [TAPW-1:0]          wiper,
    output logic [SLOTS*TAPW-1:0]    slots
);
    localparam int SW = $clog2(SLOTS);

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        localparam logic [TAPW-1:0] RST_VAL = (s == 0) ? INIT : '0;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                slots[s*TAPW +: TAPW] <= RST_VAL;
            else if (slot_we && slot_idx == SW'(s))
                slots[s*TAPW +: TAPW] <= slot_din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            wiper <= '0;
        else if (recall)
            wiper <= slots[TAPW-1:0];
        else if (wiper_we)
            wiper <= wiper_din;
    end
endmodule

// File: rtl/dual_wiper_bank.sv
module dual_wiper_bank
    import wbk_pkg::*;
#(
    parameter int NPOT         = 2,
    parameter int SLOTS        = 4,
    parameter int TAPW         = 6,
    parameter int DATAW        = 8,
    parameter int STORE_CYCLES = 64,
    parameter logic [NPOT*TAPW-1:0] INIT_TAPS = {NPOT{6'd32}},
    localparam int PW = $clog2(NPOT),
    localparam int SW = $clog2(SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [2:0]           cmd_op,
    input  logic [PW-1:0]        cmd_pot,
    input  logic [SW-1:0]        cmd_slot,
    input  logic [DATAW-1:0]     cmd_wdata,
    input  logic                 write_lock,
    output logic [NPOT*TAPW-1:0] tap_sel,
    output logic                 rd_valid,
    output logic [DATAW-1:0]     rd_data,
    output logic                 busy,
    output logic                 cmd_refused
);
    logic in_recall, in_store;
    logic is_rd, is_wiper_wr, is_slot_wr, is_reserved;
    logic store_req, refuse_now, wiper_go;
    logic [TAPW-1:0] wd_low, sel_wiper, sel_slot, rd_val, wiper_din, slot_din;
    logic [TAPW-1:0] wip_arr [NPOT];
    logic [SLOTS*TAPW-1:0] slot_arr [NPOT];
    logic unused_wdata_hi;

    assign wd_low          = cmd_wdata[TAPW-1:0];
    assign unused_wdata_hi = ^cmd_wdata[DATAW-1:TAPW];

    always_comb begin
        is_rd = 1'b0; is_wiper_wr = 1'b0; is_slot_wr = 1'b0; is_reserved = 1'b0;
        case (cmd_op)
            OP_RD_WIPER, OP_RD_SLOT: is_rd       = 1'b1;
            OP_WR_WIPER, OP_LOAD:    is_wiper_wr = 1'b1;
            OP_WR_SLOT, OP_SAVE:     is_slot_wr  = 1'b1;
            default:                 is_reserved = 1'b1;
        endcase
    end

    assign busy       = in_recall | in_store;
    assign store_req  = cmd_valid & is_slot_wr & ~busy & ~write_lock;
    assign wiper_go   = cmd_valid & is_wiper_wr & ~in_recall;
    assign refuse_now = cmd_valid & (in_recall | is_reserved |
                                     (is_slot_wr & (busy | write_lock)));

    always_comb begin
        sel_wiper = wip_arr[cmd_pot];
        sel_slot  = slot_arr[cmd_pot][cmd_slot*TAPW +: TAPW];
        rd_val    = (cmd_op == OP_RD_WIPER) ? sel_wiper : sel_slot;
        wiper_din = (cmd_op == OP_LOAD) ? sel_slot : wd_low;
        slot_din  = (cmd_op == OP_SAVE) ? sel_wiper : wd_low;
    end

    wbk_seq #(.STORE_CYCLES(STORE_CYCLES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .store_req (store_req),
        .in_recall (in_recall),
        .in_store  (in_store)
    );

    for (genvar p = 0; p < NPOT; p++) begin : g_pot
        wbk_channel #(
            .TAPW  (TAPW),
            .SLOTS (SLOTS),
            .INIT  (INIT_TAPS[p*TAPW +: TAPW])
        ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .recall    (in_recall),
            .wiper_we  (wiper_go && cmd_pot == PW'(p)),
            .wiper_din (wiper_din),
            .slot_we   (store_req && cmd_pot == PW'(p)),
            .slot_idx  (cmd_slot),
            .slot_din  (slot_din),
            .wiper     (wip_arr[p]),
            .slots     (slot_arr[p])
        );
        assign tap_sel[p*TAPW +: TAPW] = wip_arr[p];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid    <= 1'b0;
            rd_data     <= '0;
            cmd_refused <= 1'b0;
        end else begin
            rd_valid    <= cmd_valid & is_rd & ~in_recall;
            cmd_refused <= refuse_now;
            if (cmd_valid && is_rd)
                rd_data <= DATAW'(rd_val);
        end
    end
endmodule

// File: rtl/wbk_chk.sv
module wbk_chk
    import wbk_pkg::*;
#(
    parameter int NPOT         = 2,
    parameter int TAPW         = 6,
    parameter int DATAW        = 8,
    parameter int STORE_CYCLES = 64,
    localparam int PW = $clog2(NPOT)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cmd_valid,
    input logic [2:0]           cmd_op,
    input logic [PW-1:0]        cmd_pot,
    input logic [DATAW-1:0]     cmd_wdata,
    input logic                 write_lock,
    input logic                 in_recall,
    input logic [NPOT*TAPW-1:0] tap_sel,
    input logic                 rd_valid,
    input logic [DATAW-1:0]     rd_data,
    input logic                 busy,
    input logic                 cmd_refused
);
    int unsigned run_q;
    logic wr_seen_q;
    logic [PW-1:0] wr_pot_q;
    logic [TAPW-1:0] wr_val_q;
    logic slot_cmd;

    assign slot_cmd = cmd_valid && (cmd_op == OP_WR_SLOT || cmd_op == OP_SAVE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q     <= 0;
            wr_seen_q <= 1'b0;
            wr_pot_q  <= '0;
            wr_val_q  <= '0;
        end else begin
            run_q     <= busy ? run_q + 1 : 0;
            wr_seen_q <= cmd_valid && cmd_op == OP_WR_WIPER && !in_recall;
            wr_pot_q  <= cmd_pot;
            wr_val_q  <= cmd_wdata[TAPW-1:0];
        end
    end

    // R2
    wiper_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_seen_q |-> tap_sel[wr_pot_q*TAPW +: TAPW] == wr_val_q);
    // R3
    read_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> rd_data[DATAW-1:TAPW] == '0);
    // R7
    busy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> run_q < STORE_CYCLES);
    // R8
    busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_cmd && busy) |=> cmd_refused);
    // R9
    lock_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_cmd && write_lock) |=> cmd_refused);
    // R10
    reserved_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op[2:1] == 2'b11) |=> cmd_refused);
    // R11
    recall_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && in_recall) |=> (cmd_refused && !rd_valid));
endmodule

bind dual_wiper_bank wbk_chk #(
    .NPOT(NPOT), .TAPW(TAPW), .DATAW(DATAW), .STORE_CYCLES(STORE_CYCLES)
) u_wbk_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_pot(cmd_pot), .cmd_wdata(cmd_wdata), .write_lock(write_lock),
    .in_recall(in_recall), .tap_sel(tap_sel), .rd_valid(rd_valid),
    .rd_data(rd_data), .busy(busy), .cmd_refused(cmd_refused)
);

// File: tb/dual_wiper_bank_tb_top.sv
module dual_wiper_bank_tb_top;
    localparam int SC = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [2:0] cmd_op = '0;
    logic cmd_pot = 1'b0;
    logic [1:0] cmd_slot = '0;
    logic [7:0] cmd_wdata = '0;
    logic write_lock = 1'b0;
    logic [11:0] tap_sel;
    logic rd_valid, busy, cmd_refused;
    logic [7:0] rd_data;

    always #2.5 clk = ~clk;

    dual_wiper_bank #(
        .STORE_CYCLES(SC), .INIT_TAPS({6'd21, 6'd42})
    ) dut_i (.*);

    int vectors = 0, misses = 0, cycles = 0;
    bit started = 0;

    // behavioural reference model
    int m_wcr [2];
    int m_dr [2][4];
    int m_mode, m_cnt, m_rdd;
    bit m_rdv, m_rej;

    task automatic chk(string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        started <= 1;
        cycles  <= cycles + 1;
        if (!rst_n) begin
            for (int p = 0; p < 2; p++) begin
                m_wcr[p] = 0;
                for (int s = 0; s < 4; s++) m_dr[p][s] = 0;
            end
            m_dr[0][0] = 42; m_dr[1][0] = 21;
            m_mode = 0; m_cnt = 0; m_rdv = 0; m_rej = 0; m_rdd = 0;
        end else if (m_mode == 0) begin
            m_wcr[0] = m_dr[0][0]; m_wcr[1] = m_dr[1][0];
            m_rdv = 0; m_rej = cmd_valid; m_mode = 1;
        end else begin
            bit bsy, start;
            bsy = (m_mode != 1); start = 0; m_rdv = 0; m_rej = 0;
            if (cmd_valid) begin
                case (cmd_op)
                    0: begin m_rdv = 1; m_rdd = m_wcr[cmd_pot]; end
                    1: m_wcr[cmd_pot] = cmd_wdata % 64;
                    2: begin m_rdv = 1; m_rdd = m_dr[cmd_pot][cmd_slot]; end
                    3: if (bsy || write_lock) m_rej = 1;
                       else begin m_dr[cmd_pot][cmd_slot] = cmd_wdata % 64; start = 1; end
                    4: m_wcr[cmd_pot] = m_dr[cmd_pot][cmd_slot];
                    5: if (bsy || write_lock) m_rej = 1;
                       else begin m_dr[cmd_pot][cmd_slot] = m_wcr[cmd_pot]; start = 1; end
                    default: m_rej = 1;
                endcase
            end
            if (m_mode == 2) begin
                if (m_cnt == 1) m_mode = 1; else m_cnt--;
            end else if (start) begin
                m_mode = 2; m_cnt = SC;
            end
        end
    end

    always @(negedge clk) begin
        if (started) begin
            chk("R2 tap0", int'(tap_sel[5:0]), m_wcr[0]);
            chk("R2 tap1", int'(tap_sel[11:6]), m_wcr[1]);
            chk("R7 busy", int'(busy), int'(m_mode != 1));
            chk("R8 refused", int'(cmd_refused), int'(m_rej));
            chk("R3 rd_valid", int'(rd_valid), int'(m_rdv));
            if (m_rdv) chk("R3 rd_data", int'(rd_data), m_rdd);
        end
    end

    task automatic step(bit v, int op, int pot, int slot, int wd);
        @(negedge clk); #1;
        cmd_valid = v; cmd_op = 3'(op); cmd_pot = pot[0];
        cmd_slot = 2'(slot); cmd_wdata = 8'(wd);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset tap", int'(tap_sel), 0);
        chk("R1 reset busy", int'(busy), 1);
        rst_n = 1;
        // command in the recall cycle
        cmd_valid = 1; cmd_op = 3'd1; cmd_pot = 0; cmd_wdata = 8'd5;
        idle(1);
        chk("R11 refused", int'(cmd_refused), 1);
        chk("R1 recall tap0", int'(tap_sel[5:0]), 42);
        chk("R1 recall tap1", int'(tap_sel[11:6]), 21);
        step(1, 1, 1, 0, 8'hFF); idle(1);
        chk("R2 wiper write", int'(tap_sel[11:6]), 63);
        chk("R2 other pot", int'(tap_sel[5:0]), 42);
        step(1, 3, 0, 2, 8'hC7); idle(1);
        chk("R7 busy set", int'(busy), 1);
        step(1, 3, 0, 1, 8'h11); idle(1);
        chk("R8 refused in store", int'(cmd_refused), 1);
        step(1, 1, 0, 0, 8'h0C); idle(1);
        chk("R2 write in store", int'(tap_sel[5:0]), 12);
        step(1, 2, 0, 2, 0); idle(1);
        chk("R4 slot readback", int'(rd_data), 7);
        step(1, 2, 0, 1, 0); idle(1);
        chk("R8 slot unchanged", int'(rd_data), 0);
        idle(SC + 2);
        chk("R7 busy cleared", int'(busy), 0);
        write_lock = 1;
        step(1, 3, 1, 3, 8'h2B); idle(1);
        chk("R9 lock refused", int'(cmd_refused), 1);
        chk("R9 no store", int'(busy), 0);
        step(1, 1, 1, 0, 9); idle(1);
        chk("R9 wiper write under lock", int'(tap_sel[11:6]), 9);
        step(1, 2, 1, 3, 0); idle(1);
        chk("R9 slot unchanged", int'(rd_data), 0);
        write_lock = 0;
        step(1, 5, 1, 3, 0); idle(1);
        step(1, 2, 1, 3, 0); idle(1);
        chk("R6 save readback", int'(rd_data), 9);
        idle(SC + 2);
        step(1, 4, 0, 2, 0); idle(1);
        chk("R5 load tap0", int'(tap_sel[5:0]), 7);
        step(1, 6, 0, 0, 8'h3F); idle(1);
        chk("R10 op6 refused", int'(cmd_refused), 1);
        step(1, 7, 1, 1, 8'h3F); idle(1);
        chk("R10 op7 refused", int'(cmd_refused), 1);
        chk("R10 taps kept", int'(tap_sel), (9 << 6) | 7);
        for (int i = 0; i < 600; i++) begin
            write_lock = ($urandom % 4) == 0;
            step(($urandom % 4) != 0, $urandom % 8, $urandom % 2,
                 $urandom % 4, $urandom % 256);
        end
        idle(SC + 3);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        wait (cycles > 20000);
        misses++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule